// File: doc/BRIEF.md
# Matrix keyboard scan controller

The controller walks a keyboard matrix of up to 16 rows and 8 columns. It drives one row at a time, samples the column lines, and debounces each row's column pattern before accepting it. Every key that goes from released to pressed becomes one byte-wide entry in a small key FIFO. A count threshold on that FIFO raises an interrupt, so software reads pressed keys in bursts and never polls a raw bitmap.

All timing runs in scan ticks. A scan tick is one cycle of the slow scan clock, made here by dividing the core clock by `TICK_DIV`. Each scan pass begins with a fixed idle gap. Then every row is driven for a fixed settling window plus a programmable debounce stretch. A plain register port holds the control fields, a status register with write-one-to-clear flags, the key FIFO read location and one wake mask per row.

Top module: `kbd_matrix_scan`

Register map (word addresses on `addr_i`): 0 control, 1 status, 2 key FIFO, 16+r wake mask of row r.

## Requirements
- R1: After reset every register reads 0. `row_o`, `irq_o` and `wake_o` are 0, and reading the key location returns 0.
- R2: The control register's bit 0 enables scanning. While it is 1, each pass first drives no row for 5 x `TICK_DIV` clock cycles. Rows 0 to ROWS-1 then follow in ascending order with no gap, and each is driven (its bit alone high in `row_o`) for (16 + D) x `TICK_DIV` clock cycles, where D is the debounce count. When bit 0 is 0, `row_o` is 0 from the next cycle on.
- R3: The control register fields are: enable at bit 0, interrupt enable at bit 3, debounce count D at bits 13:4 (0 to 0x3FF), and FIFO threshold at bits 17:14. These bits read back as written and all other bits read 0.
- R4: A row's column pattern is sampled at tick 15 of its window. It is accepted only if it holds the same value at every tick up to tick 15+D. Otherwise the row keeps its previous accepted state.
- R5: Each column that changes from 0 to 1 in an accepted pattern pushes one entry into the FIFO. The entry holds the column in bits 2:0, the row in bits 6:3, and bit 7 = 1. Within a row, entries are pushed in ascending column order. Across rows, entries follow scan order.
- R6: A key held down produces no further entries. After it is released and pressed again, it produces a new entry. A key already down when scanning is enabled counts as a new press.
- R7: A read of the key location (address 2) returns the oldest entry and removes it from the FIFO. When the FIFO is empty, the read returns 0 (bit 7 clear).
- R8: Status bits 7:4 hold the number of entries in the FIFO.
- R9: Status bit 2 sets while the entry count is at least a nonzero threshold, and stays set until a 1 is written to bit 2. `irq_o` is status bit 2 AND control bit 3.
- R10: A new entry that arrives while the FIFO is full is dropped, and status bit 0 sets. A 1 written to bit 0 clears it.
- R11: Status bit 1 (driven on `wake_o`) sets when a new press lands on a column whose bit is 0 in that row's mask register (address 16+r, bits 7:0, 1 = masked). A 1 written to bit 1 clears it, and writing 0x7 to status clears bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (read of address 2 pops) |
| addr_i | input | 5 | Register word address |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Read data, combinational while rd_en_i is high |
| col_i | input | COLS | Column sense lines, 1 = key closed on the driven row |
| row_o | output | ROWS | Row drive, one-hot or zero |
| irq_o | output | 1 | FIFO threshold interrupt |
| wake_o | output | 1 | Wake event flag |

## Verification
The assertions check on every cycle that at most one row is driven and that the row drive stops once scanning is disabled. They also check that the interrupt never rises without its enable, that the FIFO count stays within its depth, that a dropped entry always sets the overflow flag, and that every pushed entry carries its valid bit. Only the bench scenarios can show that held keys stay silent and that re-pressed keys are reported again. The same holds for the exact row and gap durations, the rejection of a bouncing contact, the entry order within and across rows, and which entry is lost on overflow. The wake masks, selective clearing of status flags and the threshold crossing also need those scenarios.

// File: rtl/kbd_scan_pkg.sv
package kbd_scan_pkg;
  localparam int unsigned ADDR_W    = 5;
  localparam int unsigned DEB_W     = 10;
  localparam int unsigned THR_W     = 4;
  localparam int unsigned FIX_WIN   = 16;
  localparam int unsigned PASS_DLY  = 5;
  localparam int unsigned MASK_BASE = 16;
  localparam int unsigned ROW_FW    = 4;
  localparam int unsigned COL_FW    = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 5'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 5'd1;
  localparam logic [ADDR_W-1:0] A_KEY  = 5'd2;

  typedef struct packed {
    logic              valid;
    logic [ROW_FW-1:0] row;
    logic [COL_FW-1:0] col;
  } key_ent_t;
endpackage

// File: rtl/kbd_scan.sv
module kbd_scan
  import kbd_scan_pkg::*;
#(
  parameter int unsigned ROWS     = 16,
  parameter int unsigned COLS     = 8,
  parameter int unsigned TICK_DIV = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DEB_W-1:0]  deb_i,
  input  logic [COLS-1:0]   col_i,
  output logic [ROWS-1:0]   row_o,
  output logic              commit_o,
  output logic [ROW_FW-1:0] commit_row_o,
  output logic [COLS-1:0]   press_o
);
  localparam int unsigned DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int unsigned CNT_W = $clog2(FIX_WIN + (1 << DEB_W));

  typedef enum logic {PH_DLY, PH_ROW} phase_e;

  logic [DIV_W-1:0]           div_q;
  logic                       tick;
  phase_e                     ph_q;
  logic [CNT_W-1:0]           cnt_q;
  logic [ROW_FW-1:0]          row_q;
  logic [COLS-1:0]            samp_q;
  logic                       stab_q;
  logic [ROWS-1:0][COLS-1:0]  state_q;
  logic                       commit_q;
  logic [ROW_FW-1:0]          crow_q;
  logic [COLS-1:0]            press_q;

  logic [CNT_W-1:0] last_cnt;
  logic             at_latch, at_last, stab_now;
  logic [COLS-1:0]  new_state;

  assign tick      = en_i && (div_q == DIV_W'(TICK_DIV - 1));
  assign last_cnt  = CNT_W'(FIX_WIN - 1) + CNT_W'(deb_i);
  assign at_latch  = (cnt_q == CNT_W'(FIX_WIN - 1));
  assign at_last   = (cnt_q >= last_cnt);
  assign stab_now  = at_latch ? 1'b1 : (stab_q && (col_i == samp_q));
  assign new_state = at_latch ? col_i : samp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                div_q <= '0;
    else if (!en_i || tick)     div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= PH_DLY;
      cnt_q    <= '0;
      row_q    <= '0;
      samp_q   <= '0;
      stab_q   <= 1'b0;
      state_q  <= '0;
      commit_q <= 1'b0;
      crow_q   <= '0;
      press_q  <= '0;
    end else if (!en_i) begin
      ph_q     <= PH_DLY;
      cnt_q    <= '0;
      row_q    <= '0;
      stab_q   <= 1'b0;
      state_q  <= '0;
      commit_q <= 1'b0;
    end else begin
      commit_q <= 1'b0;
      if (tick) begin
        unique case (ph_q)
          PH_DLY: begin
            if (cnt_q == CNT_W'(PASS_DLY - 1)) begin
              ph_q  <= PH_ROW;
              cnt_q <= '0;
              row_q <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          PH_ROW: begin
            if (at_latch) begin
              samp_q <= col_i;
              stab_q <= 1'b1;
            end else if (col_i != samp_q) begin
              stab_q <= 1'b0;
            end
            if (at_last) begin
              if (stab_now) begin
                commit_q       <= 1'b1;
                press_q        <= new_state & ~state_q[row_q];
                state_q[row_q] <= new_state;
              end
              crow_q <= row_q;
              cnt_q  <= '0;
              if (row_q == ROW_FW'(ROWS - 1)) ph_q <= PH_DLY;
              else                            row_q <= row_q + 1'b1;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: ph_q <= PH_DLY;
        endcase
      end
    end
  end

  always_comb begin
    row_o = '0;
    if (ph_q == PH_ROW) row_o[row_q] = 1'b1;
  end

  assign commit_o     = commit_q;
  assign commit_row_o = crow_q;
  assign press_o      = press_q;
endmodule

// File: rtl/kbd_fifo.sv
module kbd_fifo #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = mem_q[rp_q];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end
endmodule

// File: rtl/kbd_regs.sv
module kbd_regs
  import kbd_scan_pkg::*;
#(
  parameter int unsigned ROWS  = 16,
  parameter int unsigned COLS  = 8,
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  output logic              en_o,
  output logic              int_en_o,
  output logic [DEB_W-1:0]  deb_o,
  output logic              key_pop_o,
  input  logic [7:0]        key_i,
  input  logic              key_empty_i,
  input  logic [CNT_W-1:0]  fifo_cnt_i,
  input  logic              drop_i,
  input  logic              commit_i,
  input  logic [ROW_FW-1:0] commit_row_i,
  input  logic [COLS-1:0]   press_i,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic                      en_q, ie_q;
  logic [DEB_W-1:0]          deb_q;
  logic [THR_W-1:0]          thr_q;
  logic [ROWS-1:0][COLS-1:0] mask_q;
  logic                      st_ovf_q, st_wake_q, st_thr_q;
  logic [2:0]                w1c;
  logic                      thr_hit, wake_hit;

  assign w1c      = (wr_en_i && addr_i == A_STAT) ? wr_data_i[2:0] : 3'b000;
  assign thr_hit  = (thr_q != '0) && (32'(fifo_cnt_i) >= 32'(thr_q));
  assign wake_hit = commit_i && |(press_i & ~mask_q[commit_row_i]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      ie_q  <= 1'b0;
      deb_q <= '0;
      thr_q <= '0;
    end else if (wr_en_i && addr_i == A_CTRL) begin
      en_q  <= wr_data_i[0];
      ie_q  <= wr_data_i[3];
      deb_q <= wr_data_i[4 +: DEB_W];
      thr_q <= wr_data_i[14 +: THR_W];
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_mask
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mask_q[r] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(MASK_BASE + r))
        mask_q[r] <= wr_data_i[COLS-1:0];
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_ovf_q  <= 1'b0;
      st_wake_q <= 1'b0;
      st_thr_q  <= 1'b0;
    end else begin
      st_ovf_q  <= (st_ovf_q  & ~w1c[0]) | drop_i;
      st_wake_q <= (st_wake_q & ~w1c[1]) | wake_hit;
      st_thr_q  <= (st_thr_q  & ~w1c[2]) | thr_hit;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_en_i) begin
      if (addr_i == A_CTRL) begin
        rd_data_o[0]              = en_q;
        rd_data_o[3]              = ie_q;
        rd_data_o[4 +: DEB_W]     = deb_q;
        rd_data_o[14 +: THR_W]    = thr_q;
      end else if (addr_i == A_STAT) begin
        rd_data_o[0]   = st_ovf_q;
        rd_data_o[1]   = st_wake_q;
        rd_data_o[2]   = st_thr_q;
        rd_data_o[7:4] = 4'(fifo_cnt_i);
      end else if (addr_i == A_KEY) begin
        rd_data_o[7:0] = key_empty_i ? 8'h00 : key_i;
      end else begin
        for (int r = 0; r < ROWS; r++)
          if (addr_i == ADDR_W'(MASK_BASE + r)) rd_data_o[COLS-1:0] = mask_q[r];
      end
    end
  end

  assign key_pop_o = rd_en_i && (addr_i == A_KEY);
  assign en_o      = en_q;
  assign int_en_o  = ie_q;
  assign deb_o     = deb_q;
  assign ovf_o     = st_ovf_q;
  assign irq_o     = st_thr_q & ie_q;
  assign wake_o    = st_wake_q;
endmodule

// File: rtl/kbd_matrix_scan.sv
module kbd_matrix_scan
  import kbd_scan_pkg::*;
#(
  parameter int unsigned ROWS       = 16,
  parameter int unsigned COLS       = 8,
  parameter int unsigned FIFO_DEPTH = 8,
  parameter int unsigned TICK_DIV   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wr_data_i,
  output logic [31:0]       rd_data_o,
  input  logic [COLS-1:0]   col_i,
  output logic [ROWS-1:0]   row_o,
  output logic              irq_o,
  output logic              wake_o
);
  localparam int unsigned FCNT_W = $clog2(FIFO_DEPTH + 1);

  logic              ctrl_en, ctrl_ie;
  logic [DEB_W-1:0]  ctrl_deb;
  logic              commit;
  logic [ROW_FW-1:0] commit_row;
  logic [COLS-1:0]   press;
  logic              key_pop;
  logic [7:0]        key_out;
  logic [FCNT_W-1:0] fifo_cnt;
  logic              fifo_full, fifo_empty;
  logic              st_ovf;

  // serializer: one entry per clock from the last committed row
  logic [COLS-1:0]   pend_q;
  logic [ROW_FW-1:0] prow_q;
  logic [COL_FW-1:0] first_col;
  logic              ser_push;
  key_ent_t          ser_ent;
  logic [7:0]        ser_data;

  always_comb begin
    first_col = '0;
    for (int c = COLS - 1; c >= 0; c--)
      if (pend_q[c]) first_col = COL_FW'(c);
  end

  assign ser_push = |pend_q;
  assign ser_ent  = '{valid: 1'b1, row: prow_q, col: first_col};
  assign ser_data = ser_ent;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      prow_q <= '0;
    end else if (commit) begin
      pend_q <= press;
      prow_q <= commit_row;
    end else if (ser_push) begin
      pend_q[first_col] <= 1'b0;
    end
  end

  kbd_scan #(.ROWS(ROWS), .COLS(COLS), .TICK_DIV(TICK_DIV)) i_scan (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (ctrl_en),
    .deb_i        (ctrl_deb),
    .col_i        (col_i),
    .row_o        (row_o),
    .commit_o     (commit),
    .commit_row_o (commit_row),
    .press_o      (press)
  );

  kbd_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ser_push),
    .din_i   (ser_data),
    .pop_i   (key_pop),
    .dout_o  (key_out),
    .cnt_o   (fifo_cnt),
    .full_o  (fifo_full),
    .empty_o (fifo_empty)
  );

  kbd_regs #(.ROWS(ROWS), .COLS(COLS), .CNT_W(FCNT_W)) i_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .rd_en_i      (rd_en_i),
    .addr_i       (addr_i),
    .wr_data_i    (wr_data_i),
    .rd_data_o    (rd_data_o),
    .en_o         (ctrl_en),
    .int_en_o     (ctrl_ie),
    .deb_o        (ctrl_deb),
    .key_pop_o    (key_pop),
    .key_i        (key_out),
    .key_empty_i  (fifo_empty),
    .fifo_cnt_i   (fifo_cnt),
    .drop_i       (ser_push && fifo_full),
    .commit_i     (commit),
    .commit_row_i (commit_row),
    .press_i      (press),
    .ovf_o        (st_ovf),
    .irq_o        (irq_o),
    .wake_o       (wake_o)
  );
endmodule

// File: rtl/kbd_matrix_chk.sv
module kbd_matrix_chk #(
  parameter int unsigned ROWS  = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [ROWS-1:0]  row_o,
  input logic             irq_o,
  input logic             en,
  input logic             int_en,
  input logic             push,
  input logic [7:0]       push_data,
  input logic             full,
  input logic             ovf,
  input logic             pop,
  input logic             empty,
  input logic [CNT_W-1:0] fifo_cnt
);
  // R2
  row_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(row_o));
  // R2
  row_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> (row_o == '0));
  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> int_en);
  // R10
  overflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push && full) |=> ovf);
  // R8
  fifo_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_cnt <= CNT_W'(DEPTH));
  // R7
  empty_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop && empty && !push) |=> $stable(fifo_cnt));
  // R5
  entry_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push |-> push_data[7]);
endmodule

bind kbd_matrix_scan kbd_matrix_chk #(.ROWS(ROWS), .DEPTH(FIFO_DEPTH)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .row_o     (row_o),
  .irq_o     (irq_o),
  .en        (ctrl_en),
  .int_en    (ctrl_ie),
  .push      (ser_push),
  .push_data (ser_data),
  .full      (fifo_full),
  .ovf       (st_ovf),
  .pop       (key_pop),
  .empty     (fifo_empty),
  .fifo_cnt  (fifo_cnt)
);

// File: tb/test_kbd_matrix_scan.sv
module test_kbd_matrix_scan;
  localparam int DIV  = 2;
  localparam int ROWS = 16;
  localparam int COLS = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0]       addr = '0;
  logic [31:0]      wdata = '0;
  logic [31:0]      rdata;
  logic [COLS-1:0]  col;
  logic [ROWS-1:0]  row;
  logic             irq, wake;
  logic [ROWS-1:0][COLS-1:0] keys = '0;

  int errors = 0, checks = 0, mon_pops = 0;
  bit mon_on = 1'b0, mon_busy = 1'b0;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  kbd_matrix_scan #(.ROWS(ROWS), .COLS(COLS), .FIFO_DEPTH(8), .TICK_DIV(DIV)) i_kbd_matrix_scan (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wr_data_i(wdata), .rd_data_o(rdata), .col_i(col), .row_o(row),
    .irq_o(irq), .wake_o(wake)
  );

  // key matrix model
  always_comb begin
    col = '0;
    for (int r = 0; r < ROWS; r++) if (row[r]) col |= keys[r];
  end

  function automatic logic [7:0] ent(int r, int c);
    return {1'b1, 4'(r), 3'(c)};
  endfunction

  function automatic logic [31:0] ctrl(bit en, bit ie, int deb, int thr);
    return 32'(en) | (32'(ie) << 3) | (32'(deb) << 4) | (32'(thr) << 14);
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_passes(input int n, input int deb);
    repeat (n * (5 + ROWS * (16 + deb)) * DIV + 40) @(negedge clk);
  endtask

  task automatic mon_stop();
    mon_on = 1'b0;
    @(negedge clk);
    while (mon_busy) @(negedge clk);
  endtask

  // monitor: pops entries on interrupt and compares with the scoreboard
  initial begin
    logic [31:0] d;
    forever begin
      @(negedge clk);
      if (mon_on && irq) begin
        mon_busy = 1'b1;
        bus_rd(5'd2, d);
        mon_pops++;
        if (exp_q.size() == 0) chk("R6", "unexpected entry", d[7:0], 0);
        else chk("R5", "entry", d[7:0], exp_q.pop_front());
        bus_wr(5'd1, 32'h4);
        mon_busy = 1'b0;
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int g, w, p0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1", "row_o", row, 0);
    chk("R1", "irq_o", irq, 0);
    chk("R1", "wake_o", wake, 0);
    bus_rd(5'd0, d); chk("R1", "ctrl", d, 0);
    bus_rd(5'd1, d); chk("R1", "status", d, 0);
    bus_rd(5'd2, d); chk("R7", "empty key read", d, 0);

    // R3 field readback with extra bits set
    bus_wr(5'd0, 32'h8000_0002 | ctrl(0, 1, 10'h3FF, 5));
    bus_rd(5'd0, d); chk("R3", "ctrl readback", d, ctrl(0, 1, 10'h3FF, 5));
    repeat (50) @(negedge clk);
    chk("R2", "row_o while disabled", row, 0);

    // R2 scan timing, deb=3
    bus_wr(5'd0, ctrl(1, 1, 3, 1));
    mon_on = 1'b1;
    @(negedge clk);
    while (!row[15]) @(negedge clk);
    while (row[15]) @(negedge clk);
    g = 0;
    while (row == 0) begin g++; @(negedge clk); end
    chk("R2", "pass gap cycles", g, 5 * DIV);
    chk("R2", "first row after gap", row, 16'h0001);
    w = 0;
    while (row == 16'h0001) begin w++; @(negedge clk); end
    chk("R2", "row width cycles", w, 19 * DIV);
    chk("R2", "next row contiguous", row, 16'h0002);

    // R5 single press via scoreboard
    keys[3][5] = 1'b1; exp_q.push_back(ent(3, 5));
    wait_passes(2, 3);
    chk("R5", "single press delivered", exp_q.size(), 0);
    // R6 hold: no further entries
    p0 = mon_pops;
    wait_passes(2, 3);
    chk("R6", "held key silent", mon_pops - p0, 0);

    // R5 two keys in one row: ascending columns
    keys[7][6] = 1'b1; keys[7][1] = 1'b1;
    exp_q.push_back(ent(7, 1)); exp_q.push_back(ent(7, 6));
    wait_passes(2, 3);
    chk("R5", "same-row pair delivered", exp_q.size(), 0);

    // R6 release and re-press
    keys[3][5] = 1'b0;
    p0 = mon_pops;
    wait_passes(2, 3);
    chk("R6", "release silent", mon_pops - p0, 0);
    keys[3][5] = 1'b1; exp_q.push_back(ent(3, 5));
    wait_passes(2, 3);
    chk("R6", "re-press delivered", exp_q.size(), 0);
    keys = '0;
    wait_passes(1, 3);

    // R4 bouncing contact rejected with deb=20
    bus_wr(5'd0, ctrl(1, 1, 20, 1));
    wait_passes(1, 20);
    p0 = mon_pops;
    for (int i = 0; i < 3 * (5 + ROWS * 36) / 3; i++) begin
      keys[5][2] = ~keys[5][2];
      repeat (3 * DIV) @(negedge clk);
    end
    keys[5][2] = 1'b0;
    wait_passes(2, 20);
    chk("R4", "bouncing key rejected", mon_pops - p0, 0);
    keys[5][2] = 1'b1; exp_q.push_back(ent(5, 2));
    wait_passes(2, 20);
    chk("R4", "steady key accepted", exp_q.size(), 0);
    keys = '0;
    wait_passes(1, 20);

    // R9 threshold crossing, monitor off
    mon_stop();
    bus_wr(5'd0, ctrl(1, 1, 0, 3));
    bus_wr(5'd1, 32'h7);
    keys[9][0] = 1'b1; keys[9][1] = 1'b1;
    wait_passes(2, 0);
    chk("R9", "irq below threshold", irq, 0);
    bus_rd(5'd1, d); chk("R8", "status count 2", d, 32'h22);
    keys[9][4] = 1'b1;
    wait_passes(2, 0);
    chk("R9", "irq at threshold", irq, 1);
    bus_rd(5'd1, d); chk("R9", "status count 3 thr", d, 32'h36);
    bus_wr(5'd0, ctrl(1, 0, 0, 3));
    @(negedge clk);
    chk("R9", "irq gated by enable", irq, 0);
    bus_rd(5'd2, d); chk("R7", "pop oldest", d, ent(9, 0));
    bus_rd(5'd2, d); chk("R7", "pop second", d, ent(9, 1));
    bus_rd(5'd2, d); chk("R7", "pop third", d, ent(9, 4));
    bus_rd(5'd2, d); chk("R7", "pop empty", d, 0);
    bus_wr(5'd1, 32'h4);
    bus_rd(5'd1, d); chk("R9", "w1c threshold only", d, 32'h02);
    bus_wr(5'd1, 32'h2);
    bus_rd(5'd1, d); chk("R11", "w1c wake", d, 32'h00);

    // R10 overflow: keys down before enable
    keys = '0;
    bus_wr(5'd0, ctrl(0, 0, 0, 15));
    for (int r = 0; r < 9; r++) keys[r][r % 8] = 1'b1;
    bus_wr(5'd0, ctrl(1, 0, 0, 15));
    wait_passes(2, 0);
    bus_rd(5'd1, d); chk("R10", "status full+ovf", d, 32'h83);
    for (int r = 0; r < 8; r++) begin
      bus_rd(5'd2, d); chk("R6", "pre-held key entry", d, ent(r, r % 8));
    end
    bus_rd(5'd2, d); chk("R10", "dropped entry absent", d, 0);
    bus_wr(5'd1, 32'h1);
    bus_rd(5'd1, d); chk("R10", "w1c overflow", d, 32'h02);

    // R11 wake masks
    keys = '0;
    bus_wr(5'd0, ctrl(0, 0, 0, 15));
    bus_wr(5'd1, 32'h7);
    bus_wr(5'd20, 32'hFF);
    bus_wr(5'd22, 32'hFB);
    bus_rd(5'd22, d); chk("R11", "mask readback", d, 32'hFB);
    bus_wr(5'd0, ctrl(1, 0, 0, 15));
    keys[4][3] = 1'b1;
    wait_passes(2, 0);
    chk("R11", "fully masked row no wake", wake, 0);
    bus_rd(5'd1, d); chk("R8", "masked key still queued", d, 32'h10);
    keys[6][5] = 1'b1;
    wait_passes(2, 0);
    chk("R11", "masked column no wake", wake, 0);
    keys[6][2] = 1'b1;
    wait_passes(2, 0);
    chk("R11", "unmasked column wakes", wake, 1);
    bus_wr(5'd1, 32'h7);
    @(negedge clk);
    chk("R11", "wake cleared by 0x7", wake, 0);

    // R2 disable
    bus_wr(5'd0, 32'h0);
    repeat (3) @(negedge clk);
    chk("R2", "row_o after disable", row, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule